// File: doc/BRIEF.md
# I2C Target Transaction Sequencer

This block is the target side of an I2C bus. It oversamples the SCL and SDA lines on the system clock and finds START and STOP conditions. The first byte after a START is compared with a programmable 7-bit device address. The block acknowledges that byte when it matches, and it also acknowledges address zero, which it treats as a general call. The direction bit in that byte selects the path for the rest of the message. On a master write, each byte goes into a receive FIFO. On a master read, each byte comes from a transmit FIFO. Each FIFO has a byte-wide valid/ready port facing the local logic.

The block drives SDA through a single pull-low output, as an open-drain pad would. It never drives SCL. Three status outputs report events: a general-call flag that holds until the next START, a one-cycle pulse when an addressed write ends with a STOP, and a one-cycle pulse when the master ends a read with a NACK. Any of the following returns the sequencer to idle: a START, a STOP, an address mismatch, a master NACK, a read that finds the transmit FIFO empty, or a write that finds the receive FIFO full.

Top module: `i2c_target_seq`

## Requirements
- R1: The address byte is sent MSB first: seven address bits, then a direction bit where 1 means the master reads. When the seven bits equal the programmed address, the block pulls SDA low for the whole ninth SCL high phase (ACK).
- R2: The block does not pull SDA low for an address that is neither the programmed address nor zero. It then leaves SDA released and stores nothing until the next START.
- R3: Address zero is acknowledged and raises `genCall`. A START clears `genCall`.
- R4: In a master write, each data byte is acknowledged and appended to the receive FIFO. Bytes come out of `rxData` in arrival order.
- R5: A STOP that ends an addressed master write produces a single-cycle `rxDone` pulse.
- R6: In a master read, bytes are taken from the transmit FIFO in order and driven MSB first. SDA changes only while SCL is low. A master ACK (SDA low in the ninth bit) starts the next byte.
- R7: A master NACK after a read byte empties the transmit FIFO and pulses `txDone` for one cycle.
- R8: A START anywhere in a message, including partway through a byte, restarts address reception. Partial bytes are not stored.
- R9: A read address that finds the transmit FIFO empty is not acknowledged. A master ACK that finds the FIFO empty releases the bus, and later reads return all ones with no `txDone`.
- R10: A write byte that arrives while the receive FIFO is full is not acknowledged and not stored, and the message is dropped. A later STOP gives no `rxDone`.
- R11: `cfgWrite` loads `cfgAddr` and empties both FIFOs only when the sequencer is idle. During a message it has no effect on the address or on the FIFO contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfgWrite | input | 1 | Strobe to load a new device address |
| cfgAddr | input | 7 | New device address |
| txData | input | 8 | Byte offered to the transmit FIFO |
| txValid | input | 1 | Transmit byte valid |
| txReady | output | 1 | Transmit FIFO has space |
| rxData | output | 8 | Oldest received byte |
| rxValid | output | 1 | Receive FIFO not empty |
| rxReady | input | 1 | Consumer takes `rxData` |
| genCall | output | 1 | Current message addressed zero |
| rxDone | output | 1 | Pulse: addressed write ended by STOP |
| txDone | output | 1 | Pulse: read ended by master NACK |

## Verification
A wrong sequencer state shows up on the bus within one byte. It appears as an ACK bit that is missing or extra at the ninth clock, as a read byte with shifted or all-ones bits, or as SDA held low so that the master's next bit is corrupted. Buffer-side faults appear when the FIFOs are drained after each message: a byte is lost, duplicated or stored without an ACK, or a flush is missing so a stale byte is transmitted. Status faults appear within a few cycles of the STOP or NACK, because the pulse counts are compared right after each message ends.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHK_ADDR,
    ST_SEND_ACK,
    ST_SEND_DATA,
    ST_REQ_REPLY,
    ST_CHK_REPLY,
    ST_LOAD_TX,
    ST_REQ_DATA
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic incCnt;
    logic clrCnt;
    logic loadTx;
    logic shiftTx;
    logic pushRx;
    logic flushTx;
    logic flushRx;
    logic loadAddr;
  } seqCmd_t;

  // bus events and buffer state from datapath to control
  typedef struct packed {
    logic             sclLvl;
    logic             sdaLvl;
    logic             sclRise;
    logic             sclFall;
    logic             startSeen;
    logic             stopSeen;
    logic [CNT_W-1:0] bitCnt;
    logic             addrHit;
    logic             addrZero;
    logic             txEmpty;
    logic             rxFull;
    logic             txBit;
  } busStat_t;

endpackage

// File: rtl/i2ct_fifo.sv
module i2ct_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CAP  = (AW + 1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             doWr, doRd;

  assign empty  = (count == '0);
  assign full   = (count == CAP);
  assign doWr   = wrEn && !full && !flush;
  assign doRd   = rdEn && !empty && !flush;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/i2ct_datapath.sv
module i2ct_datapath
  import i2ct_pkg::*;
#(
  parameter int         FIFO_DEPTH = 4,
  parameter logic [6:0] RESET_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  seqCmd_t           cmd,
  input  logic [6:0]        cfgAddr,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  output busStat_t          stat
);
  logic [1:0]        sclSync, sdaSync;
  logic              sclPrev, sdaPrev;
  logic              sclNow, sdaNow;
  logic [6:0]        ownAddr;
  logic [BYTE_W-1:0] rxShift, txShift, txHead;
  logic [CNT_W-1:0]  bitCnt;
  logic              txEmpty, txFull, rxEmpty, rxFull;

  assign sclNow = sclSync[1];
  assign sdaNow = sdaSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownAddr <= RESET_ADDR;
      rxShift <= '0;
      txShift <= '1;
      bitCnt  <= '0;
    end else begin
      if (cmd.loadAddr) ownAddr <= cfgAddr;
      if (cmd.incCnt) rxShift <= {rxShift[BYTE_W-2:0], sdaNow};
      if (cmd.clrCnt || cmd.loadTx) bitCnt <= '0;
      else if (cmd.incCnt)          bitCnt <= bitCnt + 1'b1;
      if (cmd.loadTx)       txShift <= txHead;
      else if (cmd.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  i2ct_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(cmd.flushTx),
    .wrEn(txValid), .wrData(txData),
    .rdEn(cmd.loadTx), .rdData(txHead),
    .empty(txEmpty), .full(txFull)
  );

  i2ct_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(cmd.flushRx),
    .wrEn(cmd.pushRx), .wrData({rxShift[BYTE_W-2:0], sdaNow}),
    .rdEn(rxReady), .rdData(rxData),
    .empty(rxEmpty), .full(rxFull)
  );

  assign txReady = !txFull;
  assign rxValid = !rxEmpty;

  always_comb begin
    stat.sclLvl    = sclNow;
    stat.sdaLvl    = sdaNow;
    stat.sclRise   = sclNow && !sclPrev;
    stat.sclFall   = !sclNow && sclPrev;
    stat.startSeen = sclNow && sclPrev && sdaPrev && !sdaNow;
    stat.stopSeen  = sclNow && sclPrev && !sdaPrev && sdaNow;
    stat.bitCnt    = bitCnt;
    stat.addrHit   = (rxShift[6:0] == ownAddr);
    stat.addrZero  = (rxShift[6:0] == 7'd0);
    stat.txEmpty   = txEmpty;
    stat.rxFull    = rxFull;
    stat.txBit     = txShift[BYTE_W-1];
  end
endmodule

// File: rtl/i2ct_control.sv
module i2ct_control
  import i2ct_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  busStat_t stat,
  input  logic     cfgWrite,
  output seqCmd_t  cmd,
  output logic     sdaPullLow,
  output logic     genCall,
  output logic     rxDone,
  output logic     txDone
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  seqState_t state, nState;
  logic      ackOn, nAck, dirRead, nDir, nGc, nRxDone, nTxDone;
  logic      unusedOk;

  assign unusedOk = stat.sclLvl;

  always_comb begin
    cmd     = '0;
    nState  = state;
    nAck    = ackOn;
    nDir    = dirRead;
    nGc     = genCall;
    nRxDone = 1'b0;
    nTxDone = 1'b0;

    if (cfgWrite && state == ST_IDLE) begin
      cmd.loadAddr = 1'b1;
      cmd.flushTx  = 1'b1;
      cmd.flushRx  = 1'b1;
    end

    if (stat.startSeen) begin
      nState     = ST_CHK_ADDR;
      nAck       = 1'b0;
      nGc        = 1'b0;
      cmd.clrCnt = 1'b1;
    end else if (stat.stopSeen) begin
      if (state != ST_IDLE && state != ST_CHK_ADDR && !dirRead) nRxDone = 1'b1;
      nState = ST_IDLE;
      nAck   = 1'b0;
    end else begin
      unique case (state)
        ST_CHK_ADDR: if (stat.sclRise) begin
          cmd.incCnt = 1'b1;
          if (stat.bitCnt == LAST_BIT) begin
            if ((stat.addrHit || stat.addrZero) && !(stat.sdaLvl && stat.txEmpty)) begin
              nState = ST_SEND_ACK;
              nDir   = stat.sdaLvl;
              nGc    = stat.addrZero;
            end else begin
              nState = ST_IDLE;
            end
          end
        end
        ST_SEND_ACK: if (stat.sclFall) begin
          if (!ackOn) nAck = 1'b1;
          else begin
            nAck = 1'b0;
            if (dirRead) begin
              cmd.loadTx = 1'b1;
              nState     = ST_SEND_DATA;
            end else begin
              cmd.clrCnt = 1'b1;
              nState     = ST_REQ_DATA;
            end
          end
        end
        ST_SEND_DATA: begin
          if (stat.sclRise) begin
            cmd.incCnt = 1'b1;
            if (stat.bitCnt == LAST_BIT) nState = ST_REQ_REPLY;
          end
          if (stat.sclFall) cmd.shiftTx = 1'b1;
        end
        ST_REQ_REPLY: if (stat.sclFall) nState = ST_CHK_REPLY;
        ST_CHK_REPLY: if (stat.sclRise) begin
          if (stat.sdaLvl) begin
            cmd.flushTx = 1'b1;
            nTxDone     = 1'b1;
            nState      = ST_IDLE;
          end else if (stat.txEmpty) begin
            nState = ST_IDLE;
          end else begin
            nState = ST_LOAD_TX;
          end
        end
        ST_LOAD_TX: if (stat.sclFall) begin
          cmd.loadTx = 1'b1;
          nState     = ST_SEND_DATA;
        end
        ST_REQ_DATA: if (stat.sclRise) begin
          cmd.incCnt = 1'b1;
          if (stat.bitCnt == LAST_BIT) begin
            if (stat.rxFull) nState = ST_IDLE;
            else begin
              cmd.pushRx = 1'b1;
              nState     = ST_SEND_ACK;
            end
          end
        end
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ackOn   <= 1'b0;
      dirRead <= 1'b0;
      genCall <= 1'b0;
      rxDone  <= 1'b0;
      txDone  <= 1'b0;
    end else begin
      state   <= nState;
      ackOn   <= nAck;
      dirRead <= nDir;
      genCall <= nGc;
      rxDone  <= nRxDone;
      txDone  <= nTxDone;
    end
  end

  assign sdaPullLow = (state == ST_SEND_ACK && ackOn) ||
                      ((state == ST_SEND_DATA || state == ST_REQ_REPLY) && !stat.txBit);
endmodule

// File: rtl/i2c_target_seq.sv
module i2c_target_seq
  import i2ct_pkg::*;
#(
  parameter int         FIFO_DEPTH = 4,
  parameter logic [6:0] RESET_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  input  logic       cfgWrite,
  input  logic [6:0] cfgAddr,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic [7:0] rxData,
  output logic       rxValid,
  input  logic       rxReady,
  output logic       genCall,
  output logic       rxDone,
  output logic       txDone
);
  seqCmd_t  seqCmd;
  busStat_t busStat;

  i2ct_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .RESET_ADDR(RESET_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .cmd(seqCmd), .cfgAddr(cfgAddr),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .stat(busStat)
  );

  i2ct_control u_ctl (
    .clk(clk), .rstN(rstN), .stat(busStat), .cfgWrite(cfgWrite),
    .cmd(seqCmd), .sdaPullLow(sdaPullLow),
    .genCall(genCall), .rxDone(rxDone), .txDone(txDone)
  );
endmodule

// File: rtl/i2c_target_seq_chk.sv
module i2c_target_seq_chk
  import i2ct_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     sdaPullLow,
  input logic     genCall,
  input logic     rxDone,
  input logic     txDone,
  input logic     txReady,
  input logic     rxValid,
  input seqCmd_t  seqCmd,
  input busStat_t busStat
);
  // R6: the data line driven by the target moves only while the clock line is low
  p_sda_moves_scl_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !$past(busStat.sclLvl));

  // R6: a transmit load never happens with an empty transmit FIFO
  p_no_empty_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    seqCmd.loadTx |-> !busStat.txEmpty);

  // R10: a receive push never happens with a full receive FIFO
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    seqCmd.pushRx |-> !busStat.rxFull);

  // R3: a START clears the general-call flag
  p_gc_cleared_r3: assert property (@(posedge clk) disable iff (!rstN)
    busStat.startSeen |=> !genCall);

  // R5: receive-complete lasts a single cycle
  p_rxdone_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  // R7: after a NACK-terminated read the transmit FIFO is empty and accepts data
  p_txdone_flushed_r7: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txReady);

  // R11: an accepted address load leaves the receive FIFO empty
  p_cfg_flush_r11: assert property (@(posedge clk) disable iff (!rstN)
    seqCmd.loadAddr |=> !rxValid);
endmodule

bind i2c_target_seq i2c_target_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .sdaPullLow(sdaPullLow), .genCall(genCall),
  .rxDone(rxDone), .txDone(txDone), .txReady(txReady), .rxValid(rxValid),
  .seqCmd(seqCmd), .busStat(busStat)
);

// File: tb/i2c_target_seq_test.sv
`timescale 1ns/1ps
module i2c_target_seq_test;
  localparam int         DEPTH = 4;
  localparam logic [6:0] ADDR0 = 7'h2A;

  typedef logic [7:0] byteQ_t[$];

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaBus;
  logic sdaPullLow, cfgWrite = 1'b0;
  logic [6:0] cfgAddr = '0;
  logic [7:0] txData = '0, rxData;
  logic txValid = 1'b0, txReady, rxValid, rxReady = 1'b0;
  logic genCall, rxDone, txDone;

  always #2.5 clk = ~clk;

  assign sdaBus = sdaM & ~sdaPullLow;

  i2c_target_seq #(.FIFO_DEPTH(DEPTH), .RESET_ADDR(ADDR0)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .genCall(genCall), .rxDone(rxDone), .txDone(txDone)
  );

  // behavioural reference state
  logic [6:0] modelOwn = ADDR0;
  byteQ_t     txModel, rxModel;
  int nChk = 0, nBad = 0;
  int rxDoneCnt = 0, txDoneCnt = 0, rxDoneExp = 0, txDoneExp = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (rxDone) rxDoneCnt++;
    if (txDone) txDoneCnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(4);
    sclM = 1'b1; waitClk(4);
    sdaM = 1'b0; waitClk(4);
    sclM = 1'b0; waitClk(2);
  endtask

  task automatic busStop();
    waitClk(2); sdaM = 1'b0; waitClk(4);
    sclM = 1'b1; waitClk(4);
    sdaM = 1'b1; waitClk(10);
  endtask

  // one bit: SCL is low on entry and on exit; returns the line level mid-high
  task automatic busBit(input logic drv, output logic seen);
    waitClk(2); sdaM = drv; waitClk(6);
    sclM = 1'b1; waitClk(4);
    seen = sdaBus; waitClk(4);
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) busBit(b[i], s);
    busBit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      busBit(1'b1, s);
      b[i] = s;
    end
    busBit(nack, s);
  endtask

  task automatic txPush(input logic [7:0] b);
    @(negedge clk); txValid = 1'b1; txData = b;
    @(negedge clk); txValid = 1'b0;
    txModel.push_back(b);
  endtask

  task automatic cfgLoad(input logic [6:0] a, input bit idleNow);
    @(negedge clk); cfgWrite = 1'b1; cfgAddr = a;
    @(negedge clk); cfgWrite = 1'b0;
    if (idleNow) begin
      modelOwn = a;
      txModel.delete();
      rxModel.delete();
    end
  endtask

  task automatic wrTxn(input logic [6:0] a, input byteQ_t d, input bit doStop);
    bit ack, alive, exp;
    busStart();
    chk(genCall == 1'b0, "R3 genCall after START", genCall, 0);
    sendByte({a, 1'b0}, ack);
    alive = (a == modelOwn) || (a == 7'd0);
    chk(ack == alive, alive ? "R1 address ACK" : "R2 address NACK", ack, alive);
    if (alive) chk(genCall == (a == 7'd0), "R3 genCall level", genCall, a == 7'd0);
    foreach (d[i]) begin
      sendByte(d[i], ack);
      exp = alive && (rxModel.size() < DEPTH);
      if (exp) rxModel.push_back(d[i]);
      chk(ack == exp, !alive ? "R2 data ignored" : (exp ? "R4 data ACK" : "R10 full NACK"), ack, exp);
      alive = exp;
    end
    if (doStop) begin
      busStop();
      if (alive) rxDoneExp++;
      chk(rxDoneCnt == rxDoneExp, "R5 rxDone count", rxDoneCnt, rxDoneExp);
    end
  endtask

  task automatic rdTxn(input logic [6:0] a, input int n, input bit lastNack);
    bit ack, alive, nk;
    logic [7:0] got, exp;
    busStart();
    chk(genCall == 1'b0, "R3 genCall after START", genCall, 0);
    sendByte({a, 1'b1}, ack);
    alive = ((a == modelOwn) || (a == 7'd0)) && (txModel.size() > 0);
    chk(ack == alive, alive ? "R1 read address ACK" : "R9 read address NACK", ack, alive);
    for (int k = 0; k < n; k++) begin
      nk = lastNack && (k == n - 1);
      recvByte(nk, got);
      exp = alive ? txModel.pop_front() : 8'hFF;
      chk(got == exp, alive ? "R6 read byte" : "R9 released bus", got, exp);
      if (alive) begin
        if (nk) begin
          txModel.delete();
          txDoneExp++;
          alive = 0;
        end else if (txModel.size() == 0) begin
          alive = 0;
        end
      end
    end
    busStop();
    chk(txDoneCnt == txDoneExp, "R7 txDone count", txDoneCnt, txDoneExp);
  endtask

  task automatic drainRx(input string req);
    logic [7:0] got, exp;
    forever begin
      @(negedge clk);
      if (!rxValid) break;
      got = rxData;
      rxReady = 1'b1;
      @(negedge clk);
      rxReady = 1'b0;
      exp = (rxModel.size() > 0) ? rxModel.pop_front() : 8'hXX;
      chk(got === exp, req, got, exp);
    end
    chk(rxModel.size() == 0, req, rxModel.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic s;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    // reset state
    chk(sdaPullLow == 1'b0, "R2 reset SDA released", sdaPullLow, 0);
    chk(rxValid == 1'b0, "R4 reset rx empty", rxValid, 0);
    chk(txReady == 1'b1, "R6 reset tx ready", txReady, 1);
    chk(genCall == 1'b0, "R3 reset genCall", genCall, 0);

    // R11: address load in idle flushes the tx FIFO; R9: read then finds it empty
    txPush(8'h01); txPush(8'h02);
    cfgLoad(7'h35, 1'b1);
    rdTxn(7'h35, 1, 1'b1);

    // R1 R4 R5: plain write
    wrTxn(7'h35, '{8'hA1, 8'hB2, 8'hC3}, 1'b1);
    drainRx("R4 rx order");

    // R2: foreign address
    wrTxn(7'h12, '{8'h5E, 8'h6F}, 1'b1);
    chk(rxValid == 1'b0, "R2 nothing stored", rxValid, 0);

    // R3: general call
    wrTxn(7'h00, '{8'h5A}, 1'b1);
    drainRx("R3 general call data");

    // R10: overfill the receive FIFO
    wrTxn(7'h35, '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50}, 1'b1);
    drainRx("R10 stored bytes");

    // R6 R7: reads ending in NACK, then flush shown by a NACKed read address
    txPush(8'h11); txPush(8'h22); txPush(8'h33);
    rdTxn(7'h35, 3, 1'b1);
    txPush(8'h44); txPush(8'h55);
    rdTxn(7'h35, 1, 1'b1);
    rdTxn(7'h35, 1, 1'b1);

    // R8: repeated START between messages and partway through a byte
    wrTxn(7'h35, '{8'h66}, 1'b0);
    wrTxn(7'h35, '{8'h88}, 1'b1);
    busStart();
    sendByte({7'h35, 1'b0}, ack);
    chk(ack, "R8 address before restart", ack, 1);
    for (int i = 0; i < 4; i++) busBit(1'b0, s);
    wrTxn(7'h35, '{8'h99}, 1'b1);
    drainRx("R8 restart data");

    // R9: master ACK with empty FIFO releases the bus
    txPush(8'hAB);
    rdTxn(7'h35, 2, 1'b1);

    // R11: address load during a message is ignored
    busStart();
    sendByte({7'h35, 1'b0}, ack);
    chk(ack, "R11 address ACK", ack, 1);
    cfgLoad(7'h10, 1'b0);
    sendByte(8'h3C, ack);
    rxModel.push_back(8'h3C);
    chk(ack, "R11 data ACK after ignored load", ack, 1);
    busStop();
    rxDoneExp++;
    chk(rxDoneCnt == rxDoneExp, "R5 rxDone count", rxDoneCnt, rxDoneExp);
    wrTxn(7'h10, '{8'h77}, 1'b1);
    drainRx("R11 rx kept");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule